// File: doc/BRIEF.md
# Instruction Store Loader

This block sits between a host register port and the write side of an engine's instruction store. Each store entry is 42 bits: a 40-bit instruction plus two even-parity bits, one for each 20-bit half. The host cannot write a 42-bit entry in one access. Instead it works through three registers. The index register selects the entry and switches load mode on or off. The low data register stages the lower 32 bits. A write to the high data register supplies the upper instruction byte and both parity bits, commits the whole entry to the store, and moves the index forward by one.

When the index steps past the last entry it wraps to zero. Reading the index register while load mode is on then returns only the mode bit, so a loader can tell that it has run off the end of the store, for example while padding a program with no-op words (encoding 0xF0000C0300, whose two parity bits are both zero). Every commit compares the supplied parity bits with the instruction. A mismatch sets a sticky error flag, and the entry is still written.

Top module: `ustore_loader`

## Requirements
- R1: After reset, load mode is off, the index is 0, the parity error flag is 0, no store write is issued and the read data is 0.
- R2: Register offsets are: index at 0x000, low data at 0x004 and high data at 0x008. Writing the index register sets load mode from bit 31 and the index from bits IW-1:0, where IW = log2(DEPTH). A read of the index register returns {mode, zeros, index} on the cycle after the read strobe.
- R3: A write to the low data register only stages the value. It causes no store write and does not move the index. Reading offset 0x004 returns the staged value.
- R4: A high data write while load mode is on produces, on the next cycle, a one-cycle store write. Its address is the index held before the write, and its data is {wdata[9:0], staged low}. The index then advances by one. Bits 41:40 of the entry are the parity bits.
- R5: A high data write while load mode is off issues no store write and leaves the index unchanged. Only bits 9:0 are kept as staged data, and reading offset 0x008 returns them.
- R6: A commit at index DEPTH-1 wraps the index to 0. In load mode, reading the index register then returns 0x80000000.
- R7: On commit, bit 40 must equal the XOR of bits 19:0 and bit 41 must equal the XOR of bits 39:20. A mismatch in either half sets the error flag on the same cycle as the store write, and the entry is still written.
- R8: The error flag holds until reset or the next write to the index register, which clears it.
- R9: Reads of offsets other than the three registers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| st_we | output | 1 | Store write enable, one cycle per commit |
| st_addr | output | IW | Store entry address |
| st_wdata | output | 42 | Store entry: parity in bits 41:40, instruction in bits 39:0 |
| par_err | output | 1 | Sticky parity mismatch flag |

## Verification
The bench drives the index to the last entry and commits twice. A design that saturated, or reported the mode bit wrongly, would show an index readback other than 0x80000000 and a third commit at an address other than 0. Parity is broken separately in the lower half and the upper half. A design that checked only one half, or used odd parity, would leave the flag clear, or would set it on the no-op pad word. The flag is then watched across a clean commit, where a non-sticky design drops it, and across an index write, where a design that never clears it keeps it set. High data writes with load mode off, and low data writes, are checked for stray store writes and index movement.

// File: rtl/ustore_pkg.sv
package ustore_pkg;
    localparam int REG_AW   = 12;
    localparam int DATA_W   = 32;
    localparam int HALF_W   = 20;
    localparam int INSN_W   = 2 * HALF_W;
    localparam int PAR_W    = 2;
    localparam int ENTRY_W  = INSN_W + PAR_W;
    localparam int HI_KEEP  = ENTRY_W - DATA_W;
    localparam int MODE_BIT = DATA_W - 1;

    localparam logic [REG_AW-1:0] OFF_INDEX = 12'h000;
    localparam logic [REG_AW-1:0] OFF_LO    = 12'h004;
    localparam logic [REG_AW-1:0] OFF_HI    = 12'h008;
endpackage

// File: rtl/ustore_parity.sv
module ustore_parity
    import ustore_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    output logic [PAR_W-1:0]   mism
);
    // Each half is compared with its own even-parity bit.
    for (genvar h = 0; h < PAR_W; h++) begin : g_half
        assign mism[h] = (^entry[h*HALF_W +: HALF_W]) ^ entry[INSN_W + h];
    end
endmodule

// File: rtl/ustore_idx_step.sv
module ustore_idx_step #(
    parameter int DEPTH = 4096,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [IW-1:0] idx,
    output logic [IW-1:0] nxt
);
    localparam bit POW2 = (DEPTH == (1 << IW));

    if (POW2) begin : g_pow2
        // Natural rollover already returns to zero.
        assign nxt = idx + IW'(1);
    end else begin : g_cmp
        assign nxt = (idx == IW'(DEPTH - 1)) ? '0 : idx + IW'(1);
    end
endmodule

// File: rtl/ustore_rdmux.sv
module ustore_rdmux
    import ustore_pkg::*;
#(
    parameter int IW = 12
) (
    input  logic [REG_AW-1:0]  addr,
    input  logic               mode,
    input  logic [IW-1:0]      idx,
    input  logic [DATA_W-1:0]  lo,
    input  logic [HI_KEEP-1:0] hi,
    output logic [DATA_W-1:0]  val
);
    always_comb begin
        case (addr)
            OFF_INDEX: val = {mode, {(DATA_W-1-IW){1'b0}}, idx};
            OFF_LO:    val = lo;
            OFF_HI:    val = {{(DATA_W-HI_KEEP){1'b0}}, hi};
            default:   val = '0;
        endcase
    end
endmodule

// File: rtl/ustore_loader.sv
module ustore_loader
    import ustore_pkg::*;
#(
    parameter int DEPTH = 4096,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [REG_AW-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                st_we,
    output logic [IW-1:0]       st_addr,
    output logic [ENTRY_W-1:0]  st_wdata,
    output logic                par_err
);
    typedef struct packed {
        logic               mode;
        logic [IW-1:0]      idx;
        logic [DATA_W-1:0]  lo;
        logic [HI_KEEP-1:0] hi;
        logic               err;
        logic               we;
        logic [IW-1:0]      waddr;
        logic [ENTRY_W-1:0] wword;
        logic [DATA_W-1:0]  rdata;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRY_W-1:0] cand_d;
    logic [PAR_W-1:0]   mism_d;
    logic [IW-1:0]      idx_nxt_d;
    logic [DATA_W-1:0]  rd_val_d;

    // Entry that a high write would commit this cycle.
    assign cand_d = {wdata[HI_KEEP-1:0], s_q.lo};

    ustore_parity u_par (
        .entry (cand_d),
        .mism  (mism_d)
    );

    ustore_idx_step #(.DEPTH(DEPTH)) u_step (
        .idx (s_q.idx),
        .nxt (idx_nxt_d)
    );

    ustore_rdmux #(.IW(IW)) u_rd (
        .addr (addr),
        .mode (s_q.mode),
        .idx  (s_q.idx),
        .lo   (s_q.lo),
        .hi   (s_q.hi),
        .val  (rd_val_d)
    );

    always_comb begin
        s_d    = s_q;
        s_d.we = 1'b0;
        if (rd_en) begin
            s_d.rdata = rd_val_d;
        end
        if (wr_en) begin
            case (addr)
                OFF_INDEX: begin
                    s_d.mode = wdata[MODE_BIT];
                    s_d.idx  = wdata[IW-1:0];
                    s_d.err  = 1'b0;
                end
                OFF_LO: begin
                    s_d.lo = wdata;
                end
                OFF_HI: begin
                    s_d.hi = wdata[HI_KEEP-1:0];
                    if (s_q.mode) begin
                        s_d.we    = 1'b1;
                        s_d.waddr = s_q.idx;
                        s_d.wword = cand_d;
                        s_d.idx   = idx_nxt_d;
                        if (|mism_d) begin
                            s_d.err = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata    = s_q.rdata;
    assign st_we    = s_q.we;
    assign st_addr  = s_q.waddr;
    assign st_wdata = s_q.wword;
    assign par_err  = s_q.err;
endmodule

// File: rtl/ustore_loader_chk.sv
module ustore_loader_chk
    import ustore_pkg::*;
#(
    parameter int IW = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [REG_AW-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic               load_mode,
    input logic               st_we,
    input logic [ENTRY_W-1:0] st_wdata,
    input logic               par_err
);
    // R4: every store write traces back to a high write in load mode
    a_r4_commit_source: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> $past(wr_en && addr == OFF_HI && load_mode));

    // R4: upper entry bits come from the high write data
    a_r4_upper_bits: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> st_wdata[ENTRY_W-1:DATA_W] == $past(wdata[HI_KEEP-1:0]));

    // R5: no commit outside load mode
    a_r5_no_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_HI && !load_mode) |=> !st_we);

    // R7: the flag only rises with a commit
    a_r7_err_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err) |-> st_we);

    // R8: the flag holds unless the index register is written
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !(wr_en && addr == OFF_INDEX)) |=> par_err);
endmodule

bind ustore_loader ustore_loader_chk #(.IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .load_mode (s_q.mode),
    .st_we     (st_we),
    .st_wdata  (st_wdata),
    .par_err   (par_err)
);

// File: tb/ustore_loader_bench.sv
module ustore_loader_bench;
    localparam int DEPTH = 16;
    localparam int IW    = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [11:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              st_we;
    logic [IW-1:0]     st_addr;
    logic [41:0]       st_wdata;
    logic              par_err;

    int checks = 0;
    int errors = 0;
    int commits = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ustore_loader #(.DEPTH(DEPTH)) u_ustore_loader (
        .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata,
        .rdata, .st_we, .st_addr, .st_wdata, .par_err
    );

    always @(negedge clk) if (rst_n && st_we) commits++;

    // {is_read, req, offset, data, expected}
    localparam logic [80:0] TBL [12] = '{
        {1'b0, 4'd2, 12'h000, 32'h8000_0003, 32'h0},
        {1'b1, 4'd2, 12'h000, 32'h0,         32'h8000_0003},
        {1'b0, 4'd3, 12'h004, 32'h1234_5678, 32'h0},
        {1'b1, 4'd3, 12'h004, 32'h0,         32'h1234_5678},
        {1'b0, 4'd4, 12'h008, 32'h0000_0AAB, 32'h0},
        {1'b1, 4'd4, 12'h000, 32'h0,         32'h8000_0004},
        {1'b1, 4'd5, 12'h008, 32'h0,         32'h0000_02AB},
        {1'b0, 4'd2, 12'h000, 32'h0000_000F, 32'h0},
        {1'b1, 4'd2, 12'h000, 32'h0,         32'h0000_000F},
        {1'b0, 4'd5, 12'h008, 32'h0000_0000, 32'h0},
        {1'b1, 4'd5, 12'h000, 32'h0,         32'h0000_000F},
        {1'b1, 4'd9, 12'h00C, 32'h0,         32'h0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int c0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 we", 64'(st_we), 64'd0);
        chk("R1 err", 64'(par_err), 64'd0);
        chk("R1 rdata", 64'(rdata), 64'd0);
        rst_n = 1'b1;
        rd(12'h000, v);
        chk("R1 index", 64'(v), 64'h0);

        // Vector table walk (R2 R3 R4 R5 R9)
        for (int i = 0; i < 12; i++) begin
            if (TBL[i][80]) begin
                rd(TBL[i][75:64], v);
                chk($sformatf("R%0d table %0d", TBL[i][79:76], i), 64'(v), 64'(TBL[i][31:0]));
            end else begin
                wr(TBL[i][75:64], TBL[i][63:32]);
            end
        end
        chk("R8 cleared by index write", 64'(par_err), 64'd0);

        // R4 commit with no-op pad word, R7 clean parity
        wr(12'h000, 32'h8000_0005);
        c0 = commits;
        wr(12'h004, 32'h000C_0300);
        chk("R3 no commit on low write", 64'(commits), 64'(c0));
        wr(12'h008, 32'h0000_00F0);
        chk("R4 we", 64'(st_we), 64'd1);
        chk("R4 addr", 64'(st_addr), 64'd5);
        chk("R4 data", 64'(st_wdata), 64'h0F0_000C_0300);
        chk("R7 nop parity ok", 64'(par_err), 64'd0);
        @(negedge clk);
        chk("R4 single pulse", 64'(st_we), 64'd0);

        // R7 lower-half mismatch, entry still written
        wr(12'h004, 32'h0000_0001);
        wr(12'h008, 32'h0000_0000);
        chk("R7 low half err", 64'(par_err), 64'd1);
        chk("R7 still written", 64'(st_we), 64'd1);
        // R8 sticky across a clean commit
        wr(12'h004, 32'h000C_0300);
        wr(12'h008, 32'h0000_00F0);
        chk("R8 sticky", 64'(par_err), 64'd1);
        wr(12'h000, 32'h8000_0000);
        chk("R8 clear", 64'(par_err), 64'd0);

        // R7 upper half: correct bit41 then missing bit41
        wr(12'h004, 32'h0010_0000);
        wr(12'h008, 32'h0000_0200);
        chk("R7 upper ok", 64'(par_err), 64'd0);
        wr(12'h008, 32'h0000_0000);
        chk("R7 upper err", 64'(par_err), 64'd1);

        // R6 wrap
        wr(12'h000, 32'h8000_000E);
        wr(12'h004, 32'h000C_0300);
        wr(12'h008, 32'h0000_00F0);
        wr(12'h008, 32'h0000_00F0);
        chk("R6 last addr", 64'(st_addr), 64'd15);
        rd(12'h000, v);
        chk("R6 wrapped readback", 64'(v), 64'h8000_0000);
        wr(12'h008, 32'h0000_00F0);
        chk("R6 commit at zero", 64'(st_addr), 64'd0);

        // R5 leave load mode, high write ignored
        wr(12'h000, 32'h0000_0000);
        c0 = commits;
        wr(12'h008, 32'h0000_00F0);
        @(negedge clk);
        chk("R5 no commit", 64'(commits), 64'(c0));
        rd(12'h000, v);
        chk("R5 index held", 64'(v), 64'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule